// File: doc/BRIEF.md
# Multi-level symbol phase demultiplexer

This block sits in the data path of a paging receiver, after symbol timing has been recovered. Each symbol is a two-bit value from 0 to 3 and arrives with a one-cycle valid strobe. The block turns each symbol into one bit, or into two bits in four-level mode, and steers those bits onto four parallel phase lines. It raises a registered strobe each time a complete output word is ready.

Two mode inputs select the symbol rate and the number of levels. The slow rate is 1600 baud and the fast rate is 3200 baud. At the slow rate every symbol produces one output word on phases A and B. At the fast rate symbols are taken in pairs: the first symbol of a pair loads phases A and B, the second loads phases C and D, and the word is emitted only after the second symbol. A phase that the mode does not use stays at zero, which downstream logic treats as idle data. A frame-start input returns all held bits and the pair position to zero.

Top module: `symphase_demux`

## Requirements
- R1: The primary bit of a symbol is 1 for symbols 0 and 1, and 0 for symbols 2 and 3. Phases appear on `phase_o` with A at bit 0, B at bit 1, C at bit 2 and D at bit 3.
- R2: In four-level mode (`mode_quad_i`=1) a secondary bit is also decoded. It is 1 for symbols 0 and 3, and 0 for symbols 1 and 2.
- R3: At the slow rate (`mode_fast_i`=0), each accepted symbol updates phase A with its primary bit, and also phase B with its secondary bit in four-level mode. `out_valid_o` is high in the cycle after the symbol.
- R4: At the fast rate (`mode_fast_i`=1), the first accepted symbol of a pair loads phases A and B and produces no strobe. The second loads phases C and D and raises `out_valid_o` in the following cycle. The word then carries the first symbol on A and B and the second on C and D.
- R5: In two-level mode (`mode_quad_i`=0), phases B and D are never updated by a symbol. They keep whatever value they held.
- R6: Phases the mode does not use read 0 after a frame start: C and D at the slow rate, and B and D in two-level mode.
- R7: A high `frame_start_i` clears all four held bits and the pair position, so the next symbol counts as the first of a pair. A symbol presented in the same cycle as `frame_start_i` is dropped.
- R8: `out_valid_o` is high for exactly one cycle per emitted word. It is low in any cycle that does not follow an accepted symbol which completes a word.
- R9: After reset, `phase_o` and `out_valid_o` are 0 and the next fast-rate symbol is the first of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Clears held bits and pair position |
| mode_fast_i | input | 1 | 1 = 3200 baud (paired symbols), 0 = 1600 baud |
| mode_quad_i | input | 1 | 1 = four-level symbols, 0 = two-level |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | 2 | Symbol value 0..3 |
| phase_o | output | 4 | Held phase bits, A at bit 0 through D at bit 3 |
| out_valid_o | output | 1 | One-cycle strobe per completed word |

## Verification
A pair position that has drifted swaps the A/B and C/D contents at the ports. The strobe then lands after the first symbol of a pair instead of the second, which shows up one cycle after the first fast-rate symbol following a frame start. A wrong decode, or a secondary bit written in two-level mode, shows on `phase_o` one cycle after the offending symbol. A clear that is missed leaves non-zero phases in the cycle right after `frame_start_i`.

// File: rtl/symphase_pkg.sv
package symphase_pkg;
  localparam int SYM_W  = 2;
  localparam int PAIRS  = 2;
  localparam int PHASES = 2 * PAIRS;
  localparam int SLOT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  // Primary bit: low half of the symbol range maps to 1
  function automatic logic primary_bit(input logic [SYM_W-1:0] s);
    return (s < SYM_W'(2));
  endfunction

  // Secondary bit: Gray mapping, outer symbols map to 1
  function automatic logic secondary_bit(input logic [SYM_W-1:0] s);
    return (s == SYM_W'(0)) || (s == SYM_W'(3));
  endfunction
endpackage

// File: rtl/sym_decode.sv
module sym_decode
  import symphase_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output logic             prim_o,
  output logic             sec_o
);
  always_comb begin
    prim_o = primary_bit(sym_i);
    sec_o  = secondary_bit(sym_i);
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import symphase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic              fast_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q;

  assign last_o = !fast_i || (slot_q == SLOT_W'(PAIRS - 1));
  assign slot_o = fast_i ? slot_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slot_q <= '0;
    else if (clear_i)     slot_q <= '0;
    else if (accept_i) begin
      if (last_o)         slot_q <= '0;
      else                slot_q <= slot_q + SLOT_W'(1);
    end
  end

  // R7: a frame start always returns the pair position to its first slot
  assert_slot_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (slot_q == '0));
endmodule

// File: rtl/phase_bank.sv
module phase_bank
  import symphase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic              quad_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              prim_i,
  input  logic              sec_i,
  output logic [PHASES-1:0] phase_o
);
  logic [PAIRS-1:0] prim_q;
  logic [PAIRS-1:0] sec_q;
  logic [PAIRS-1:0] load;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign load[p] = accept_i && (slot_i == SLOT_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prim_q[p] <= 1'b0;
      else if (clear_i)   prim_q[p] <= 1'b0;
      else if (load[p])   prim_q[p] <= prim_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sec_q[p] <= 1'b0;
      else if (clear_i)           sec_q[p] <= 1'b0;
      else if (load[p] && quad_i) sec_q[p] <= sec_i;
    end

    assign phase_o[2*p]   = prim_q[p];
    assign phase_o[2*p+1] = sec_q[p];
  end

  // R5: two-level symbols never touch the secondary bits
  assert_two_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_i && (|load) && !clear_i) |=> $stable(sec_q));

  // R1: the first-slot primary bit follows the loaded symbol
  assert_primary_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load[0] && !clear_i) |=> (prim_q[0] == ($past(sym_i) <= SYM_W'(1))));
endmodule

// File: rtl/symphase_demux.sv
module symphase_demux
  import symphase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             mode_fast_i,
  input  logic             mode_quad_i,
  input  logic             sym_valid_i,
  input  logic [1:0]       sym_i,
  output logic [3:0]       phase_o,
  output logic             out_valid_o
);
  logic              accept;
  logic              emit;
  logic              prim;
  logic              sec;
  logic              last_slot;
  logic [SLOT_W-1:0] slot;
  logic              valid_q;

  assign accept = sym_valid_i && !frame_start_i;
  assign emit   = accept && last_slot;

  sym_decode u_dec (
    .sym_i  (sym_i),
    .prim_o (prim),
    .sec_o  (sec)
  );

  slot_ctrl u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (frame_start_i),
    .accept_i (accept),
    .fast_i   (mode_fast_i),
    .slot_o   (slot),
    .last_o   (last_slot)
  );

  phase_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (frame_start_i),
    .accept_i (accept),
    .quad_i   (mode_quad_i),
    .slot_i   (slot),
    .sym_i    (sym_i),
    .prim_i   (prim),
    .sec_i    (sec),
    .phase_o  (phase_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= emit;
  end
  assign out_valid_o = valid_q;

  // R8: a strobe only ever follows an accepted symbol
  assert_strobe_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(sym_valid_i && !frame_start_i));

  // R3: slow rate emits once per symbol
  assert_slow_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_fast_i) |=> out_valid_o);

  // R4: first symbol of a fast pair produces no strobe
  assert_fast_first_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_fast_i && (slot == '0)) |=> !out_valid_o);

  // R7: frame start leaves all phases at zero and no strobe
  assert_frame_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> ((phase_o == 4'b0) && !out_valid_o));
endmodule

// File: tb/symphase_demux_tb.sv
module symphase_demux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       mode_fast_i = 1'b0;
  logic       mode_quad_i = 1'b0;
  logic       sym_valid_i = 1'b0;
  logic [1:0] sym_i = 2'd0;
  logic [3:0] phase_o;
  logic       out_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  symphase_demux dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .mode_fast_i(mode_fast_i), .mode_quad_i(mode_quad_i),
    .sym_valid_i(sym_valid_i), .sym_i(sym_i),
    .phase_o(phase_o), .out_valid_o(out_valid_o)
  );

  // bench-side decode, written from the requirement tables
  function automatic logic ref_a(input int s);
    return (s == 0) || (s == 1);
  endfunction
  function automatic logic ref_b(input int s);
    return !((s == 1) || (s == 2));
  endfunction

  task automatic check_out(input string req, input logic ev, input logic [3:0] ep);
    checks++;
    if (out_valid_o !== ev || phase_o !== ep) begin
      errors++;
      $display("FAIL %s: valid=%0b phase=%b expected valid=%0b phase=%b",
               req, out_valid_o, phase_o, ev, ep);
    end
  endtask

  // one symbol; returns at the next falling edge, after the register update
  task automatic push(input int s);
    @(negedge clk);
    sym_valid_i = 1'b1;
    sym_i = 2'(s);
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  task automatic frame_start();
    @(negedge clk);
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  task automatic t_reset();
    check_out("R9 reset", 1'b0, 4'b0000);
  endtask

  task automatic t_slow_quad();
    frame_start();
    mode_fast_i = 0; mode_quad_i = 1;
    for (int s = 0; s < 4; s++) begin
      push(s);
      check_out("R1 R2 R3 slow quad", 1'b1, {2'b00, ref_b(s), ref_a(s)});
    end
    @(negedge clk);
    check_out("R8 strobe one cycle", 1'b0, {2'b00, ref_b(3), ref_a(3)});
  endtask

  task automatic t_slow_two();
    frame_start();
    mode_fast_i = 0; mode_quad_i = 0;
    push(0);
    check_out("R5 R6 slow two-level sym0", 1'b1, 4'b0001);
    push(3);
    check_out("R6 slow two-level sym3", 1'b1, 4'b0000);
  endtask

  task automatic t_mode_switch_hold();
    frame_start();
    mode_fast_i = 0; mode_quad_i = 1;
    push(0);
    check_out("R2 load B", 1'b1, 4'b0011);
    mode_quad_i = 0;
    push(2);
    check_out("R5 B held in two-level", 1'b1, 4'b0010);
  endtask

  task automatic t_fast_quad();
    frame_start();
    mode_fast_i = 1; mode_quad_i = 1;
    push(0);
    check_out("R4 first of pair silent", 1'b0, 4'b0011);
    push(1);
    check_out("R4 pair (0,1)", 1'b1, 4'b0111);
    push(3);
    check_out("R4 first of second pair", 1'b0, 4'b0110);
    push(0);
    check_out("R4 pair (3,0)", 1'b1, 4'b1110);
    @(negedge clk);
    check_out("R8 fast strobe one cycle", 1'b0, 4'b1110);
  endtask

  task automatic t_fast_two();
    frame_start();
    mode_fast_i = 1; mode_quad_i = 0;
    push(0);
    push(1);
    check_out("R5 R6 fast two-level", 1'b1, 4'b0101);
  endtask

  task automatic t_frame_clear();
    frame_start();
    mode_fast_i = 1; mode_quad_i = 1;
    push(0);
    frame_start();
    check_out("R7 clear mid-pair", 1'b0, 4'b0000);
    push(2);
    check_out("R7 slot reset first silent", 1'b0, 4'b0000);
    push(0);
    check_out("R7 slot reset pair (2,0)", 1'b1, 4'b1100);
  endtask

  task automatic t_collision();
    mode_fast_i = 0; mode_quad_i = 1;
    push(0);
    @(negedge clk);
    frame_start_i = 1'b1; sym_valid_i = 1'b1; sym_i = 2'd1;
    @(negedge clk);
    frame_start_i = 1'b0; sym_valid_i = 1'b0;
    check_out("R7 symbol dropped at frame start", 1'b0, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slow_quad();
    t_slow_two();
    t_mode_switch_hold();
    t_fast_quad();
    t_fast_two();
    t_frame_clear();
    t_collision();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule